// File: doc/BRIEF.md
# Reloadable Time-Constant Baud Generator

This block derives a serial bit clock from a fixed reference clock. A 16-bit down counter starts from a programmable time constant and counts to zero. It then spends one extra cycle reloading and flips a divide-by-two output stage. Each output half-period therefore lasts TC+2 reference cycles, and the full output period is 2·(TC+2) cycles. For a reference frequency f and an oversampling factor M in the attached receiver, the constant for a bit rate B is TC = f / (2·B·M) − 2.

Software loads the constant one byte at a time, low byte and high byte, and can read the full 16-bit value back at any time. The constant should be loaded while the generator is idle. A byte that is rewritten while the generator runs does not cut the current half-period short. The new value is picked up at the next reload. Every reload raises a one-cycle terminal-count pulse that is aligned with the output edge.

Top module: `baud_tc_gen`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), clk_out is 0, tc_pulse is 0 and tc_rd reads 0x0000.
- R2: A write with wr_byte_en bit 0 set loads wr_data into bits 7:0 of the constant, and bit 1 loads bits 15:8. The new value appears on tc_rd one cycle after the write edge. A byte whose enable bit is clear keeps its value.
- R3: While en is low, clk_out is held at 0, tc_pulse stays 0, and writes to the constant cause no output activity.
- R4: Counting from the first clock edge at which en is sampled high, clk_out first toggles at edge TC+2 and then every TC+2 edges, giving a full period of 2·(TC+2) reference cycles.
- R5: tc_pulse is high for exactly one cycle at each reload, in the same cycle that the new clk_out level appears. clk_out never changes while enabled without tc_pulse.
- R6: A change to the constant while the generator runs leaves the half-period in progress at its old length. The next half-period uses the new constant.
- R7: With a 9.8304 MHz reference and factor 1, the constants 0x3FFE, 0x0FFE, 0x01FE, 0x00FE and 0x007E give half-periods of 16384, 4096, 512, 256 and 128 cycles (300, 1200, 9600, 19200 and 38400 baud).
- R8: A constant of 0x0000 makes clk_out toggle every 2 reference cycles.
- R9: Taking en low clears clk_out at the next edge without a pulse. Raising en again restarts a full TC+2 count from the constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable for the generator |
| wr_byte_en | input | 2 | Byte write strobes: bit 0 low byte, bit 1 high byte |
| wr_data | input | 8 | Byte written into the constant |
| tc_rd | output | 16 | Read-back of the time constant |
| clk_out | output | 1 | Divided bit clock |
| tc_pulse | output | 1 | One-cycle pulse at each reload |

## Verification
A written byte shows on tc_rd one cycle after its write edge. The first output toggle lands TC+2 edges after en is first sampled high, and each later toggle lands TC+2 edges after the one before. The pulse appears in the same cycle as the toggle, and a drop of en clears the output one edge later. The bench keeps a running edge counter and schedules every expected pulse as an absolute cycle number with its level before it starts a run. The monitor samples on the falling clock edge, pops each scheduled item when a pulse appears, and compares both the cycle and the clk_out level, so an early, late, missing or unexpected toggle each produces a mismatch.

// File: rtl/baud_gen_pkg.sv
// Package: shared types for the baud generator.
// Assumes: nothing beyond IEEE 1800-2017.
package baud_gen_pkg;

    // Counter phase: counting down, or the single reload cycle after zero
    typedef enum logic {
        PH_COUNT  = 1'b0,
        PH_RELOAD = 1'b1
    } bg_phase_e;

endpackage

// File: rtl/bg_tc_regs.sv
// Module: bg_tc_regs
// Holds the time constant as NUM_BYTES byte-wide registers, each written
// by its own strobe. Assumes the strobes are synchronous to clk.
module bg_tc_regs #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 2,
    localparam int CNT_W    = BYTE_W * NUM_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] wr_byte_en,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [CNT_W-1:0]     tc_value
);

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        // Byte b of the constant: cleared on reset, loaded on its strobe
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tc_value[b*BYTE_W +: BYTE_W] <= '0;
            end else if (wr_byte_en[b]) begin
                tc_value[b*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/bg_down_counter.sv
// Module: bg_down_counter
// Down counter that runs from the constant to zero, then spends one
// reload cycle loading the constant again. The reload cycle is flagged on
// reload_now. While disabled it holds the current constant.
// Assumes the constant is sampled only at reload or while idle.
module bg_down_counter
    import baud_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] tc_value,
    output logic             reload_now
);

    logic [CNT_W-1:0] cnt_q;
    bg_phase_e        phase_q;

    // Counter and phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= PH_COUNT;
        end else if (!en) begin
            cnt_q   <= tc_value;
            phase_q <= PH_COUNT;
        end else begin
            unique case (phase_q)
                PH_COUNT: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_RELOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_RELOAD: begin
                    cnt_q   <= tc_value;
                    phase_q <= PH_COUNT;
                end
                default: phase_q <= PH_COUNT;
            endcase
        end
    end

    // Reload cycle seen by the output stage
    always_comb begin
        reload_now = en && (phase_q == PH_RELOAD);
    end

endmodule

// File: rtl/bg_toggle.sv
// Module: bg_toggle
// Divide-by-two output stage plus the registered reload pulse. Both
// update at the same edge, so the pulse marks the cycle of the new level.
// Assumes reload_now is high for at most one cycle in a row.
module bg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic reload_now,
    output logic clk_out,
    output logic tc_pulse
);

    // Output flip and pulse register; idle forces both low
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            clk_out  <= 1'b0;
            tc_pulse <= 1'b0;
        end else begin
            clk_out  <= clk_out ^ reload_now;
            tc_pulse <= reload_now;
        end
    end

endmodule

// File: rtl/baud_tc_gen.sv
// Module: baud_tc_gen (top)
// Reloadable time-constant baud generator: byte-loaded constant, down
// counter with a reload cycle, and divide-by-two output. Half-period is
// TC+2 reference cycles. Assumes the constant is loaded while en is low.
module baud_tc_gen #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 2,
    localparam int CNT_W    = BYTE_W * NUM_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [NUM_BYTES-1:0] wr_byte_en,
    input  logic [BYTE_W-1:0]    wr_data,
    output logic [CNT_W-1:0]     tc_rd,
    output logic                 clk_out,
    output logic                 tc_pulse
);

    logic [CNT_W-1:0] tc_value;
    logic             reload_now;

    bg_tc_regs #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_byte_en (wr_byte_en),
        .wr_data    (wr_data),
        .tc_value   (tc_value)
    );

    bg_down_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .tc_value   (tc_value),
        .reload_now (reload_now)
    );

    bg_toggle u_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .reload_now (reload_now),
        .clk_out    (clk_out),
        .tc_pulse   (tc_pulse)
    );

    // Read-back of the stored constant
    always_comb begin
        tc_rd = tc_value;
    end

endmodule

// File: rtl/bg_checker.sv
// Module: bg_checker
// Port-level properties of baud_tc_gen, attached with bind below.
// Assumes reset is held for more than one cycle at start.
module bg_checker #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 2,
    localparam int CNT_W    = BYTE_W * NUM_BYTES
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic [NUM_BYTES-1:0] wr_byte_en,
    input logic [BYTE_W-1:0]    wr_data,
    input logic [CNT_W-1:0]     tc_rd,
    input logic                 clk_out,
    input logic                 tc_pulse
);

    // R2
    tc_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_byte_en[0] |=> tc_rd[BYTE_W-1:0] == $past(wr_data));

    // R2
    tc_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_byte_en[NUM_BYTES-1] |=> tc_rd[CNT_W-1 -: BYTE_W] == $past(wr_data));

    // R2
    tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|wr_byte_en) |=> $stable(tc_rd));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!clk_out && !tc_pulse));

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

    // R5
    pulse_marks_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> (clk_out != $past(clk_out)));

    // R5
    edge_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && (clk_out != $past(clk_out))) |-> tc_pulse);

endmodule

bind baud_tc_gen bg_checker #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES)
) u_bg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .wr_byte_en (wr_byte_en),
    .wr_data    (wr_data),
    .tc_rd      (tc_rd),
    .clk_out    (clk_out),
    .tc_pulse   (tc_pulse)
);

// File: tb/tb_baud_tc_gen.sv
// Bench: scoreboard of expected toggle cycles for baud_tc_gen.
module tb_baud_tc_gen;

    localparam int WATCHDOG = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  wr_byte_en = 2'b00;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] tc_rd;
    logic        clk_out;
    logic        tc_pulse;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        int    at;
        logic  lvl;
        string req;
    } exp_t;

    exp_t exp_q[$];

    baud_tc_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .wr_byte_en (wr_byte_en),
        .wr_data    (wr_data),
        .tc_rd      (tc_rd),
        .clk_out    (clk_out),
        .tc_pulse   (tc_pulse)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        if (cyc == WATCHDOG) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Monitor: every pulse must match the next scheduled toggle
    always @(negedge clk) begin
        if (rst_n && tc_pulse) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R5", "unexpected pulse at cycle", cyc, -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cyc == e.at, e.req, "toggle cycle", cyc, e.at);
                check(clk_out == e.lvl, e.req, "toggle level", clk_out, e.lvl);
            end
        end
    end

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic write_tc(input logic [15:0] v);
        wr_byte_en = 2'b01;
        wr_data    = v[7:0];
        @(negedge clk);
        wr_byte_en = 2'b10;
        wr_data    = v[15:8];
        @(negedge clk);
        wr_byte_en = 2'b00;
        @(negedge clk);
    endtask

    // Driver: load constant, enable, schedule n toggles, then stop
    task automatic run_halves(input int tc, input int n, input string req);
        int c;
        write_tc(tc[15:0]);
        c  = cyc;
        en = 1'b1;
        for (int k = 1; k <= n; k++) begin
            exp_q.push_back('{at: c + k * (tc + 2), lvl: logic'(k % 2), req: req});
        end
        wait_cyc(c + n * (tc + 2));
        en = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, req, "missing toggles", exp_q.size(), 0);
        check(clk_out == 1'b0, "R9", "clk_out after disable", clk_out, 0);
        exp_q.delete();
        @(negedge clk);
    endtask

    initial begin
        int c;
        int quiet_bad;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(clk_out == 1'b0, "R1", "clk_out after reset", clk_out, 0);
        check(tc_pulse == 1'b0, "R1", "tc_pulse after reset", tc_pulse, 0);
        check(tc_rd == 16'h0000, "R1", "tc_rd after reset", tc_rd, 0);

        // R2 byte writes and read-back
        wr_byte_en = 2'b01; wr_data = 8'hA5;
        @(negedge clk);
        wr_byte_en = 2'b00;
        check(tc_rd == 16'h00A5, "R2", "low byte read-back", tc_rd, 16'h00A5);
        wr_byte_en = 2'b10; wr_data = 8'h3C;
        @(negedge clk);
        wr_byte_en = 2'b00;
        check(tc_rd == 16'h3CA5, "R2", "high byte read-back", tc_rd, 16'h3CA5);
        wr_byte_en = 2'b01; wr_data = 8'h11;
        @(negedge clk);
        wr_byte_en = 2'b00;
        check(tc_rd == 16'h3C11, "R2", "high byte kept", tc_rd, 16'h3C11);

        // R3 idle: no activity while disabled, even across writes
        quiet_bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (i == 10) begin wr_byte_en = 2'b11; wr_data = 8'h02; end
            else wr_byte_en = 2'b00;
            @(negedge clk);
            if (clk_out || tc_pulse) quiet_bad++;
        end
        check(quiet_bad == 0, "R3", "active cycles while idle", quiet_bad, 0);

        // R4 several constants
        run_halves(3, 4, "R4");
        run_halves(37, 3, "R4");

        // R8 zero constant
        run_halves(0, 6, "R8");

        // R7 rates at 9.8304 MHz, factor 1
        run_halves(16'h007E, 3, "R7 38400");
        run_halves(16'h00FE, 3, "R7 19200");
        run_halves(16'h01FE, 3, "R7 9600");
        run_halves(16'h0FFE, 2, "R7 1200");
        run_halves(16'h3FFE, 3, "R7 300");

        // R6 constant change mid-run: old half completes, then new one
        write_tc(16'd20);
        c  = cyc;
        en = 1'b1;
        exp_q.push_back('{at: c + 22, lvl: 1'b1, req: "R6"});
        exp_q.push_back('{at: c + 44, lvl: 1'b0, req: "R6"});
        exp_q.push_back('{at: c + 51, lvl: 1'b1, req: "R6"});
        exp_q.push_back('{at: c + 58, lvl: 1'b0, req: "R6"});
        wait_cyc(c + 30);
        write_tc(16'd5);
        wait_cyc(c + 58);
        en = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R6", "missing toggles", exp_q.size(), 0);
        exp_q.delete();

        // R9 stop mid-count and restart with a full count
        write_tc(16'd10);
        c  = cyc;
        en = 1'b1;
        exp_q.push_back('{at: c + 12, lvl: 1'b1, req: "R9"});
        wait_cyc(c + 18);
        en = 1'b0;
        @(negedge clk);
        check(clk_out == 1'b0, "R9", "clk_out cleared on disable", clk_out, 0);
        wait_cyc(c + 25);
        en = 1'b1;
        exp_q.push_back('{at: c + 37, lvl: 1'b1, req: "R9"});
        exp_q.push_back('{at: c + 49, lvl: 1'b0, req: "R9"});
        wait_cyc(c + 49);
        en = 1'b0;
        @(negedge clk);
        check(exp_q.size() == 0, "R9", "missing toggles", exp_q.size(), 0);

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule